// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port memory. It watches the enable and address presented on a left port and a right port. When both ports are enabled on the same location, it decides which access goes ahead. The port whose request settled on an earlier clock edge wins. The port that arrived later is told it is busy, and any write it attempts is suppressed inside the block. The memory array and its data paths are not part of this block. Arrival order is judged on rising clock edges.

Each port request is captured on a rising edge. Every output reflects the requests captured at the most recent edge. A static mode input picks one of two roles:

- As a master, the block arbitrates and drives both active-low busy outputs. These are push-pull outputs that are always driven.
- As a slave, the block holds its busy outputs inactive. It takes active-low busy inputs from an external master and uses them only to block writes.

Top module: `dpc_arbiter`

## Requirements
- R1: While reset is asserted and just after it, both busy outputs are high (inactive) and both gated write outputs are low.
- R2: The two ports collide only when both are enabled and their addresses are equal. If the addresses differ or either port is disabled, both busy outputs stay high. In master mode, each gated write then equals that port's enable AND write request.
- R3: In master mode, suppose one port's enable and address were already captured unchanged on an earlier edge. If the other port then changes to a colliding request, the newcomer's busy output goes low in the cycle after its request is captured, and the settled port's busy output stays high.
- R4: In master mode, if both ports' requests change on the same edge and collide, the left port wins. The right busy output goes low.
- R5: A busy indication persists while the collision persists. It clears one cycle after the captured request of either port stops colliding, whether through an address change or an enable going low.
- R6: The left and right busy outputs are never low at the same time.
- R7: In master mode, a port whose busy output is low has its gated write forced low. This holds whatever level is on that port's busy input pin. A write request alone, with no address or enable change, does not change which port wins.
- R8: In slave mode, both busy outputs stay high. Each port's gated write is its enable AND its write request AND its busy input being high, regardless of any address match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; requests are captured on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| masterMode | input | 1 | Static role select: 1 = master (arbitrates), 0 = slave |
| leftEn | input | 1 | Left port enable |
| leftWe | input | 1 | Left port write request |
| leftAddr | input | ADDR_W (13) | Left port address |
| rightEn | input | 1 | Right port enable |
| rightWe | input | 1 | Right port write request |
| rightAddr | input | ADDR_W (13) | Right port address |
| leftBusyInN | input | 1 | Active-low busy from an external master; used only in slave mode |
| rightBusyInN | input | 1 | Active-low busy from an external master; used only in slave mode |
| leftBusyN | output | 1 | Active-low busy toward the left port, push-pull |
| rightBusyN | output | 1 | Active-low busy toward the right port, push-pull |
| leftWrEn | output | 1 | Left write enable after busy gating |
| rightWrEn | output | 1 | Right write enable after busy gating |

## Verification
The hardest case to reach from the ports is a tie: both ports change their requests on the same edge while the change also keeps or creates a collision. Examples are both ports appearing together on one address, or both ports jumping together from one shared address to another. The stimulus drives both ports in the same cycle to force these ties. It then contrasts them with sequences where one port is held fixed for a cycle before the other joins, so that the tie-break and the arrival-order rule are both seen to pick the loser. Write-only changes during a held collision, and asserted busy input pins in master mode, show that neither alters the outcome.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // control -> datapath: which side loses the current collision
  typedef struct packed {
    logic busyLeft;
    logic busyRight;
  } busyStrobe_t;

  // datapath -> control: comparison results on the captured requests
  typedef struct packed {
    logic match;
    logic freshLeft;
    logic freshRight;
  } dpStatus_t;

  localparam int PORT_LEFT  = 0;
  localparam int PORT_RIGHT = 1;
  localparam int NUM_PORTS  = 2;
endpackage

// File: rtl/dpc_datapath.sv
module dpc_datapath
  import dpc_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             masterMode,
  input  logic [NUM_PORTS-1:0]             portEn,
  input  logic [NUM_PORTS-1:0]             portWe,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] portAddr,
  input  logic [NUM_PORTS-1:0]             busyInN,
  input  busyStrobe_t                      strobe,
  output dpStatus_t                        status,
  output logic [NUM_PORTS-1:0]             busyOutN,
  output logic [NUM_PORTS-1:0]             wrEn
);
  logic [NUM_PORTS-1:0]             stEn, stWe, prvEn, fresh, loseBit, busyEff;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] stAddr, prvAddr;

  assign loseBit[PORT_LEFT]  = strobe.busyLeft;
  assign loseBit[PORT_RIGHT] = strobe.busyRight;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gPort
    // capture stage plus a copy of the previous capture
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stEn[p]    <= 1'b0;
        stWe[p]    <= 1'b0;
        stAddr[p]  <= '0;
        prvEn[p]   <= 1'b0;
        prvAddr[p] <= '0;
      end else begin
        stEn[p]    <= portEn[p];
        stWe[p]    <= portWe[p];
        stAddr[p]  <= portAddr[p];
        prvEn[p]   <= stEn[p];
        prvAddr[p] <= stAddr[p];
      end
    end

    // request key = enable + address; a disabled port's address is irrelevant
    assign fresh[p]    = (stEn[p] != prvEn[p]) ||
                         (stEn[p] && (stAddr[p] != prvAddr[p]));
    assign busyEff[p]  = masterMode ? loseBit[p] : ~busyInN[p];
    assign busyOutN[p] = ~(masterMode & loseBit[p]);
    assign wrEn[p]     = stEn[p] & stWe[p] & ~busyEff[p];
  end

  assign status.match      = stEn[PORT_LEFT] & stEn[PORT_RIGHT] &
                             (stAddr[PORT_LEFT] == stAddr[PORT_RIGHT]);
  assign status.freshLeft  = fresh[PORT_LEFT];
  assign status.freshRight = fresh[PORT_RIGHT];
endmodule

// File: rtl/dpc_ctrl.sv
module dpc_ctrl
  import dpc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  dpStatus_t   status,
  output busyStrobe_t strobe
);
  owner_e ownerQ, winner;

  always_comb begin
    winner = OWN_NONE;
    if (status.match) begin
      if (ownerQ == OWN_LEFT && !status.freshLeft)
        winner = OWN_LEFT;
      else if (ownerQ == OWN_RIGHT && !status.freshRight)
        winner = OWN_RIGHT;
      else if (status.freshLeft && !status.freshRight)
        winner = OWN_RIGHT;   // right settled earlier
      else
        winner = OWN_LEFT;    // left settled earlier, or a same-edge tie
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ownerQ <= OWN_NONE;
    else        ownerQ <= winner;
  end

  assign strobe.busyLeft  = (winner == OWN_RIGHT);
  assign strobe.busyRight = (winner == OWN_LEFT);
endmodule

// File: rtl/dpc_arbiter.sv
module dpc_arbiter
  import dpc_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              masterMode,
  input  logic              leftEn,
  input  logic              leftWe,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              rightEn,
  input  logic              rightWe,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              leftBusyInN,
  input  logic              rightBusyInN,
  output logic              leftBusyN,
  output logic              rightBusyN,
  output logic              leftWrEn,
  output logic              rightWrEn
);
  busyStrobe_t                      strobe;
  dpStatus_t                        status;
  logic [NUM_PORTS-1:0]             busyOutN, wrEn;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] addrVec;

  assign addrVec[PORT_LEFT]  = leftAddr;
  assign addrVec[PORT_RIGHT] = rightAddr;

  dpc_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .masterMode (masterMode),
    .portEn     ({rightEn, leftEn}),
    .portWe     ({rightWe, leftWe}),
    .portAddr   (addrVec),
    .busyInN    ({rightBusyInN, leftBusyInN}),
    .strobe     (strobe),
    .status     (status),
    .busyOutN   (busyOutN),
    .wrEn       (wrEn)
  );

  dpc_ctrl ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .status (status),
    .strobe (strobe)
  );

  assign leftBusyN  = busyOutN[PORT_LEFT];
  assign rightBusyN = busyOutN[PORT_RIGHT];
  assign leftWrEn   = wrEn[PORT_LEFT];
  assign rightWrEn  = wrEn[PORT_RIGHT];
endmodule

// File: rtl/dpc_arbiter_chk.sv
module dpc_arbiter_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              masterMode,
  input logic              leftEn,
  input logic              leftWe,
  input logic [ADDR_W-1:0] leftAddr,
  input logic              rightEn,
  input logic              rightWe,
  input logic [ADDR_W-1:0] rightAddr,
  input logic              leftBusyN,
  input logic              rightBusyN,
  input logic              leftWrEn,
  input logic              rightWrEn
);
  logic inMatch;
  assign inMatch = leftEn && rightEn && (leftAddr == rightAddr);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (leftBusyN && rightBusyN && !leftWrEn && !rightWrEn)); // R1

  AST_NO_MATCH_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(inMatch)) |-> (leftBusyN && rightBusyN)); // R2

  AST_NEVER_BOTH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(!leftBusyN && !rightBusyN)); // R6

  AST_LEFT_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (masterMode && !leftBusyN) |-> !leftWrEn); // R7

  AST_RIGHT_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (masterMode && !rightBusyN) |-> !rightWrEn); // R7

  AST_LEFT_WRITE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (masterMode && $past(rst_n) && leftBusyN) |->
      (leftWrEn == ($past(leftEn) && $past(leftWe)))); // R7

  AST_SLAVE_OUTPUTS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !masterMode |-> (leftBusyN && rightBusyN)); // R8
endmodule

bind dpc_arbiter dpc_arbiter_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .masterMode (masterMode),
  .leftEn     (leftEn),
  .leftWe     (leftWe),
  .leftAddr   (leftAddr),
  .rightEn    (rightEn),
  .rightWe    (rightWe),
  .rightAddr  (rightAddr),
  .leftBusyN  (leftBusyN),
  .rightBusyN (rightBusyN),
  .leftWrEn   (leftWrEn),
  .rightWrEn  (rightWrEn)
);

// File: tb/dpc_arbiter_tb.sv
module dpc_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 13;
  localparam int WATCHDOG   = 20000;

  typedef struct {
    logic  bl, br, wl, wr;  // expected busy (active-high here) and gated writes
    string req;
  } expItem_t;

  logic clk = 1'b0, rst_n = 1'b0, masterMode = 1'b1;
  logic leftEn = 1'b0, leftWe = 1'b0, rightEn = 1'b0, rightWe = 1'b0;
  logic [ADDR_W-1:0] leftAddr = '0, rightAddr = '0;
  logic leftBusyInN = 1'b1, rightBusyInN = 1'b1;
  logic leftBusyN, rightBusyN, leftWrEn, rightWrEn;

  int nChecks = 0, nFails = 0;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dpc_arbiter #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .masterMode(masterMode),
    .leftEn(leftEn), .leftWe(leftWe), .leftAddr(leftAddr),
    .rightEn(rightEn), .rightWe(rightWe), .rightAddr(rightAddr),
    .leftBusyInN(leftBusyInN), .rightBusyInN(rightBusyInN),
    .leftBusyN(leftBusyN), .rightBusyN(rightBusyN),
    .leftWrEn(leftWrEn), .rightWrEn(rightWrEn)
  );

  task automatic compare(input expItem_t e);
    nChecks++;
    if (leftBusyN !== ~e.bl || rightBusyN !== ~e.br ||
        leftWrEn !== e.wl || rightWrEn !== e.wr) begin
      nFails++;
      $display("FAIL %s: got busyN L=%b R=%b wr L=%b R=%b, expected busyN L=%b R=%b wr L=%b R=%b",
               e.req, leftBusyN, rightBusyN, leftWrEn, rightWrEn,
               ~e.bl, ~e.br, e.wl, e.wr);
    end
  endtask

  // driver: apply one request pair and queue what the next edge must produce
  task automatic apply(input logic le, input logic [ADDR_W-1:0] la, input logic lw,
                       input logic re, input logic [ADDR_W-1:0] ra, input logic rw,
                       input logic bil, input logic bir,
                       input logic ebl, input logic ebr, input logic ewl, input logic ewr,
                       input string req);
    expItem_t e;
    @(negedge clk);
    leftEn = le; leftAddr = la; leftWe = lw;
    rightEn = re; rightAddr = ra; rightWe = rw;
    leftBusyInN = bil; rightBusyInN = bir;
    e.bl = ebl; e.br = ebr; e.wl = ewl; e.wr = ewr; e.req = req;
    expQ.push_back(e);
  endtask

  // monitor: compare away from the edge
  always @(posedge clk) begin
    if (rst_n && expQ.size() > 0) begin
      #1;
      compare(expQ.pop_front());
    end
  end

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  task automatic resetCheck(input string req);
    expItem_t e;
    e.bl = 0; e.br = 0; e.wl = 0; e.wr = 0; e.req = req;
    compare(e);
  endtask

  task automatic doReset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; masterMode = mode;
    leftEn = 0; rightEn = 0; leftWe = 0; rightWe = 0;
    leftBusyInN = 1; rightBusyInN = 1;
    repeat (2) @(negedge clk);
    resetCheck("R1 during reset");
    rst_n = 1'b1;
    @(posedge clk); #1;
    resetCheck("R1 after reset");
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    doReset(1'b1);
    // master mode                    L:en addr we  R:en addr we  pins  exp bl br wl wr
    apply(0, 13'd0, 0,   0, 13'd0, 0,   1, 1,  0, 0, 0, 0, "R2 both idle");
    apply(1, 13'd5, 1,   1, 13'd6, 1,   1, 1,  0, 0, 1, 1, "R2 distinct addresses");
    apply(1, 13'd5, 1,   0, 13'd5, 1,   1, 1,  0, 0, 1, 0, "R2 right disabled same addr");
    apply(1, 13'd5, 0,   1, 13'd5, 1,   1, 1,  0, 1, 0, 0, "R3 right arrives late");
    apply(1, 13'd5, 1,   1, 13'd5, 1,   1, 1,  0, 1, 1, 0, "R7 write-only change keeps winner");
    apply(1, 13'd7, 1,   1, 13'd5, 1,   1, 1,  0, 0, 1, 1, "R5 winner moves, busy clears");
    apply(1, 13'd5, 1,   1, 13'd5, 1,   1, 1,  1, 0, 0, 1, "R3 left arrives late");
    apply(1, 13'd5, 1,   0, 13'd5, 1,   1, 1,  0, 0, 1, 0, "R5 winner disables, busy clears");
    apply(0, 13'd0, 0,   0, 13'd0, 0,   1, 1,  0, 0, 0, 0, "R2 idle again");
    apply(1, 13'h1FFF, 1, 1, 13'h1FFF, 1, 1, 1,  0, 1, 1, 0, "R4 same-edge tie");
    apply(1, 13'h1FFF, 1, 1, 13'h1FFF, 1, 0, 1,  0, 1, 1, 0, "R7 busy pin ignored in master");
    apply(1, 13'h1FFF, 1, 1, 13'h1FFF, 1, 1, 1,  0, 1, 1, 0, "R5 busy held while colliding");
    apply(1, 13'd0, 1,   1, 13'd0, 1,   1, 1,  0, 1, 1, 0, "R4 both jump together");
    apply(1, 13'd0, 1,   1, 13'd1, 1,   1, 1,  0, 0, 1, 1, "R5 loser moves away");
    apply(1, 13'd1, 0,   1, 13'd1, 1,   1, 1,  1, 0, 0, 1, "R6 left newcomer loses");
    apply(0, 13'd0, 0,   0, 13'd0, 0,   1, 1,  0, 0, 0, 0, "R2 idle end master");
    repeat (3) @(negedge clk);

    doReset(1'b0);
    // slave mode: pins gate writes, outputs stay high
    apply(1, 13'd5, 1,   1, 13'd5, 1,   1, 1,  0, 0, 1, 1, "R8 slave collision no gating");
    apply(1, 13'd5, 1,   1, 13'd5, 1,   1, 0,  0, 0, 1, 0, "R8 slave right pin busy");
    apply(1, 13'd5, 1,   1, 13'd5, 1,   0, 1,  0, 0, 0, 1, "R8 slave left pin busy");
    apply(1, 13'd9, 0,   1, 13'd3, 1,   0, 0,  0, 0, 0, 0, "R8 slave both pins busy");
    apply(1, 13'd9, 1,   0, 13'd3, 1,   1, 1,  0, 0, 1, 0, "R8 slave disabled port no write");
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule